// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block is the pending-interrupt register for six peripheral sources in a small controller. Each source reports an event: two 8-bit timers, a compare-match timer pair that runs as two 8-bit halves or as one 16-bit counter, an A/D converter, and a low-power direct-transfer event. Those events set flag bits. The timers are watched through their live count values, and the block itself detects when a count wraps. The converter is watched through its busy level. The compare and sleep events arrive as single-cycle pulses.

Software reads all flags as one 8-bit word. It acknowledges a source by writing a 0 to that bit. Writing a 1 never sets a flag. Each flag also drives a level interrupt line. The bus port is plain and has no back-pressure: a selected write takes effect at the next clock edge, and the read data always shows the current flags. One build parameter removes the second timer source, and its bit then reads 0 at all times.

Top module: `irq_req_reg`

## Requirements
- R1: After reset, every flag bit and every interrupt line is 0.
- R2: A write (bus_sel=1 and bus_wr=1) clears each implemented flag whose write-data bit is 0 and leaves the bits written 1 unchanged. A write never sets a flag. Without bus_sel, a write has no effect.
- R3: When a set event and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R4: Bit 0 sets when tmrb_count goes from 0xFF in one cycle to 0x00 in the next. A step from 0x00 to 0xFF and any other step do not set it. The first count seen after reset is never treated as a wrap.
- R5: Bit 1 sets when tmrc_count steps from 0xFF to 0x00, or from 0x00 to 0xFF.
- R6: Bit 3 sets on tmrf_lo_match only while tmrf_wide_mode=0. When tmrf_wide_mode=1, the pulse is ignored.
- R7: Bit 4 sets on tmrf_hi_match when tmrf_wide_mode=0 and on tmrf_word_match when tmrf_wide_mode=1. In each mode, the pulse meant for the other mode is ignored.
- R8: Bit 6 sets in the cycle where adc_busy falls from 1 to 0.
- R9: Bit 7 sets when sleep_req, xfer_enable and xfer_done are all 1 in the same cycle.
- R10: Bits 5 and 2 always read 0, and writes to them are ignored.
- R11: With HAS_TMR_C=0, bit 1 always reads 0, and no count pattern sets it.
- R12: irq_lvl equals the flag word at all times, so each line stays high while its flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe (used with bus_sel) |
| bus_wdata | input | 8 | Write data; a 0 bit clears that flag |
| bus_rdata | output | 8 | Current flag word |
| tmrb_count | input | CNT_W | Live count of timer B |
| tmrc_count | input | CNT_W | Live count of timer C (up/down) |
| tmrf_wide_mode | input | 1 | 1 = timer F runs as one 16-bit counter |
| tmrf_lo_match | input | 1 | Low-half compare match pulse |
| tmrf_hi_match | input | 1 | High-half compare match pulse |
| tmrf_word_match | input | 1 | 16-bit compare match pulse |
| adc_busy | input | 1 | Converter busy level |
| sleep_req | input | 1 | Sleep request pulse |
| xfer_enable | input | 1 | Direct transfer enable level |
| xfer_done | input | 1 | Direct transfer performed pulse |
| irq_lvl | output | 8 | Level interrupt lines, one per flag bit |

## Verification
Each timer count is driven through sequences that include the true wrap and near misses, such as the reverse step for the up-only timer and non-wrapping increments, so edge-based detection can be told apart from plain value matching. The compare pulses are applied in both timer modes, which shows whether the mode input steers the high flag and gates the low flag. Clearing writes are tried with 1 bits, with a select held low, with a selective mask, and in the same cycle as a set event, which separates clear-only behaviour from plain register loading and shows that the set has priority. A second instance built without timer C receives the same stimulus and must keep bit 1 at 0.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

  localparam int REG_W    = 8;

  // Bit positions software decodes
  localparam int BIT_TMRB = 0;
  localparam int BIT_TMRC = 1;
  localparam int BIT_TFL  = 3;
  localparam int BIT_TFH  = 4;
  localparam int BIT_ADC  = 6;
  localparam int BIT_XFER = 7;

  typedef logic [REG_W-1:0] flag_vec_t;

  typedef enum logic [1:0] {
    WRAP_UP   = 2'd0,
    WRAP_DOWN = 2'd1,
    WRAP_BOTH = 2'd2
  } wrap_kind_e;

  // Which bits hold a real flag for a given build
  function automatic flag_vec_t impl_mask(input bit has_tmr_c);
    flag_vec_t m;
    m = '0;
    m[BIT_TMRB] = 1'b1;
    m[BIT_TMRC] = has_tmr_c;
    m[BIT_TFL]  = 1'b1;
    m[BIT_TFH]  = 1'b1;
    m[BIT_ADC]  = 1'b1;
    m[BIT_XFER] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_wrap_detect.sv
module irq_wrap_detect
  import irq_req_pkg::*;
#(
  parameter int         CNT_W = 8,
  parameter wrap_kind_e KIND  = WRAP_UP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_BOT = '0;

  logic [CNT_W-1:0] prev_q;
  logic             seen_q;
  logic             up_hit;
  logic             down_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= count;
      seen_q <= 1'b1;
    end
  end

  assign up_hit   = seen_q && (prev_q == CNT_TOP) && (count == CNT_BOT);
  assign down_hit = seen_q && (prev_q == CNT_BOT) && (count == CNT_TOP);

  generate
    if (KIND == WRAP_UP) begin : g_up
      assign wrap = up_hit;
    end else if (KIND == WRAP_DOWN) begin : g_down
      assign wrap = down_hit;
    end else begin : g_both
      assign wrap = up_hit | down_hit;
    end
  endgenerate

endmodule

// File: rtl/irq_event_decode.sv
module irq_event_decode
  import irq_req_pkg::*;
#(
  parameter int        CNT_W = 8,
  parameter flag_vec_t IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tmrb_count,
  input  logic [CNT_W-1:0] tmrc_count,
  input  logic             tmrf_wide_mode,
  input  logic             tmrf_lo_match,
  input  logic             tmrf_hi_match,
  input  logic             tmrf_word_match,
  input  logic             adc_busy,
  input  logic             sleep_req,
  input  logic             xfer_enable,
  input  logic             xfer_done,
  output flag_vec_t        set_vec
);

  logic      b_wrap;
  logic      c_wrap;
  logic      busy_q;
  flag_vec_t raw;

  irq_wrap_detect #(.CNT_W(CNT_W), .KIND(WRAP_UP)) u_wrap_b (
    .clk   (clk),
    .rst   (rst),
    .count (tmrb_count),
    .wrap  (b_wrap)
  );

  irq_wrap_detect #(.CNT_W(CNT_W), .KIND(WRAP_BOTH)) u_wrap_c (
    .clk   (clk),
    .rst   (rst),
    .count (tmrc_count),
    .wrap  (c_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= adc_busy;
  end

  always_comb begin
    raw           = '0;
    raw[BIT_TMRB] = b_wrap;
    raw[BIT_TMRC] = c_wrap;
    raw[BIT_TFL]  = !tmrf_wide_mode && tmrf_lo_match;
    raw[BIT_TFH]  = tmrf_wide_mode ? tmrf_word_match : tmrf_hi_match;
    raw[BIT_ADC]  = busy_q && !adc_busy;
    raw[BIT_XFER] = sleep_req && xfer_enable && xfer_done;
  end

  assign set_vec = raw & IMPL;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_req_pkg::*;
#(
  parameter flag_vec_t IMPL = '1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_strobe,
  input  flag_vec_t wdata,
  input  flag_vec_t set_vec,
  output flag_vec_t flags
);

  flag_vec_t clr_vec;
  flag_vec_t nxt;

  always_comb begin
    clr_vec = wr_strobe ? ~wdata : '0;
    // a set in the same cycle beats a clear
    nxt     = IMPL & (set_vec | (flags & ~clr_vec));
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nxt;
  end

endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg
  import irq_req_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter bit HAS_TMR_C = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [CNT_W-1:0] tmrb_count,
  input  logic [CNT_W-1:0] tmrc_count,
  input  logic             tmrf_wide_mode,
  input  logic             tmrf_lo_match,
  input  logic             tmrf_hi_match,
  input  logic             tmrf_word_match,
  input  logic             adc_busy,
  input  logic             sleep_req,
  input  logic             xfer_enable,
  input  logic             xfer_done,
  output logic [7:0]       irq_lvl
);

  localparam flag_vec_t IMPL = impl_mask(HAS_TMR_C);

  flag_vec_t set_vec;
  flag_vec_t flag_q;
  logic      wr_strobe;

  assign wr_strobe = bus_sel && bus_wr;

  irq_event_decode #(.CNT_W(CNT_W), .IMPL(IMPL)) u_decode (
    .clk             (clk),
    .rst             (rst),
    .tmrb_count      (tmrb_count),
    .tmrc_count      (tmrc_count),
    .tmrf_wide_mode  (tmrf_wide_mode),
    .tmrf_lo_match   (tmrf_lo_match),
    .tmrf_hi_match   (tmrf_hi_match),
    .tmrf_word_match (tmrf_word_match),
    .adc_busy        (adc_busy),
    .sleep_req       (sleep_req),
    .xfer_enable     (xfer_enable),
    .xfer_done       (xfer_done),
    .set_vec         (set_vec)
  );

  irq_flag_bank #(.IMPL(IMPL)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_strobe (wr_strobe),
    .wdata     (bus_wdata),
    .set_vec   (set_vec),
    .flags     (flag_q)
  );

  assign bus_rdata = flag_q;
  assign irq_lvl   = flag_q;

endmodule

// File: rtl/irq_req_reg_chk.sv
module irq_req_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       tmrf_wide_mode,
  input logic [7:0] set_vec,
  input logic [7:0] flags,
  input logic [7:0] bus_rdata
);

  localparam logic [7:0] RSVD = 8'h24;

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((flags & ~$past(flags) & ~$past(set_vec)) == 8'h00)); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr) |=> ((flags & ~$past(bus_wdata) & ~$past(set_vec)) == 8'h00)); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_vec != 8'h00) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R3

  AST_FL_WIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tmrf_wide_mode && !flags[3]) |=> !flags[3]); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rst |-> ((bus_rdata & RSVD) == 8'h00)); // R10

endmodule

bind irq_req_reg irq_req_reg_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_sel        (bus_sel),
  .bus_wr         (bus_wr),
  .bus_wdata      (bus_wdata),
  .tmrf_wide_mode (tmrf_wide_mode),
  .set_vec        (set_vec),
  .flags          (flag_q),
  .bus_rdata      (bus_rdata)
);

// File: tb/irq_req_reg_test.sv
`timescale 1ns/1ps
module irq_req_reg_test;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] tmrb_count = 8'h00;
  logic [7:0] tmrc_count = 8'h00;
  logic       tmrf_wide_mode = 1'b0;
  logic       tmrf_lo_match = 1'b0;
  logic       tmrf_hi_match = 1'b0;
  logic       tmrf_word_match = 1'b0;
  logic       adc_busy = 1'b0;
  logic       sleep_req = 1'b0;
  logic       xfer_enable = 1'b0;
  logic       xfer_done = 1'b0;
  logic [7:0] rdata, lvl, rdata_noc, lvl_noc;

  item_t q[$];
  int    total = 0;
  int    fails = 0;
  bit    done  = 1'b0;

  always #4 clk = ~clk;

  irq_req_reg uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .tmrb_count(tmrb_count), .tmrc_count(tmrc_count),
    .tmrf_wide_mode(tmrf_wide_mode), .tmrf_lo_match(tmrf_lo_match),
    .tmrf_hi_match(tmrf_hi_match), .tmrf_word_match(tmrf_word_match),
    .adc_busy(adc_busy), .sleep_req(sleep_req),
    .xfer_enable(xfer_enable), .xfer_done(xfer_done), .irq_lvl(lvl)
  );

  irq_req_reg #(.HAS_TMR_C(1'b0)) uut_noc (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_noc),
    .tmrb_count(tmrb_count), .tmrc_count(tmrc_count),
    .tmrf_wide_mode(tmrf_wide_mode), .tmrf_lo_match(tmrf_lo_match),
    .tmrf_hi_match(tmrf_hi_match), .tmrf_word_match(tmrf_word_match),
    .adc_busy(adc_busy), .sleep_req(sleep_req),
    .xfer_enable(xfer_enable), .xfer_done(xfer_done), .irq_lvl(lvl_noc)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words as the driver posts them
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      it = q.pop_front();
      check(it.tag, rdata, it.exp);
      check({it.tag, " R12 level"}, lvl, it.exp);
      check({it.tag, " R11 no timer C"}, rdata_noc, it.exp & 8'hFD);
    end
  end

  // driver: one clock edge, post the expected word, clear pulses
  task automatic step(input logic [7:0] exp, input string tag);
    @(posedge clk);
    #2;
    q.push_back('{exp, tag});
    @(negedge clk);
    bus_sel = 1'b0;
    bus_wr = 1'b0;
    tmrf_lo_match = 1'b0;
    tmrf_hi_match = 1'b0;
    tmrf_word_match = 1'b0;
    sleep_req = 1'b0;
    xfer_done = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    bus_sel = 1'b1;
    bus_wr = 1'b1;
    bus_wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(8'h00, "R1 reset");
    // timer B: down step ignored, up wrap sets
    tmrb_count = 8'hFF; step(8'h00, "R4 down step ignored");
    tmrb_count = 8'h00; step(8'h01, "R4 up wrap");
    tmrb_count = 8'h01; step(8'h01, "R4 hold");
    wr(8'hFE);          step(8'h00, "R2 clear by zero");
    wr(8'hFF);          step(8'h00, "R2 write one no set");
    // timer C
    tmrc_count = 8'hFF; step(8'h02, "R5 down wrap");
    tmrc_count = 8'h00; wr(8'hFD); step(8'h02, "R3 set beats clear");
    wr(8'h00);          step(8'h00, "R2 clear all");
    tmrc_count = 8'h01; step(8'h00, "R5 no wrap");
    // timer F 8-bit
    tmrf_lo_match = 1'b1; step(8'h08, "R6 low match");
    tmrf_hi_match = 1'b1; step(8'h18, "R7 high match");
    tmrf_word_match = 1'b1; step(8'h18, "R7 word ignored 8-bit");
    wr(8'h00);          step(8'h00, "R2 clear");
    // timer F 16-bit
    tmrf_wide_mode = 1'b1;
    tmrf_lo_match = 1'b1; tmrf_hi_match = 1'b1; step(8'h00, "R6 R7 halves ignored 16-bit");
    tmrf_word_match = 1'b1; step(8'h10, "R7 word match");
    tmrf_wide_mode = 1'b0;
    wr(8'h00);          step(8'h00, "R2 clear");
    // converter
    adc_busy = 1'b1;    step(8'h00, "R8 busy rise");
    adc_busy = 1'b0;    step(8'h40, "R8 busy fall");
    // direct transfer
    sleep_req = 1'b1; xfer_done = 1'b1; step(8'h40, "R9 not enabled");
    xfer_enable = 1'b1; sleep_req = 1'b1; step(8'h40, "R9 no transfer");
    sleep_req = 1'b1; xfer_done = 1'b1; step(8'hC0, "R9 transfer");
    wr(8'hFF);          step(8'hC0, "R10 R2 ones write");
    bus_wr = 1'b1; bus_wdata = 8'h00; step(8'hC0, "R2 unselected write");
    wr(8'hBF);          step(8'h80, "R2 selective clear");
    wr(8'h24);          step(8'h00, "R10 reserved write");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule